// File: doc/BRIEF.md
# Write-protected enhanced register bank

This block holds the host-visible control registers of one UART channel. The host reaches them over a plain bus made of an address, write data, a write strobe and combinational read data. The bank contains four ordinary registers: interrupt enable, interrupt status, FIFO control and modem control. Each of them carries an upper "enhanced" bit-field. The bank also holds a feature register and an 8-bit scratchpad. The current value of every register is driven out to the rest of the UART.

Bit 4 of the feature register is an unlock bit. While it is 1, host writes update every bit of the four ordinary registers. While it is 0, the enhanced fields keep their latched values, and only the standard bits of those registers take the written data. This prevents legacy software from corrupting the enhanced configuration. The standard bits are stored and passed through without any decoding.

Top module: `enh_regbank`

## Requirements
- R1: After the asynchronous reset every stored bit is 0, including the scratchpad and all feature register bits, so all field outputs and all reads return 0x00.
- R2: A write to the scratchpad (address 5) stores all 8 bits, whatever the unlock state, and the host reads the same value back.
- R3: A write to the feature register (address 4) stores all 8 bits, whatever the unlock state. Its bit 4 is the unlock bit.
- R4: While the unlock bit is 1, a write stores all 8 bits of interrupt enable (address 0), interrupt status (address 1), FIFO control (address 2) and modem control (address 3).
- R5: While the unlock bit is 0, a write leaves the protected fields unchanged: interrupt enable bits 7:4, interrupt status bits 5:4, FIFO control bits 5:4 and modem control bits 7:5. The other bits of the same write take the written value.
- R6: A change of the unlock bit applies from the clock edge that stores the feature write. A write in the following cycle sees the new state. Clearing the unlock bit freezes the current protected values.
- R7: rdata_o returns the stored value of the addressed register in the same cycle. Addresses 6 and 7 read as 0x00.
- R8: A cycle with we_i low changes no stored bit, whatever addr_i and wdata_i are.
- R9: Each field output equals the value stored in its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ier_o | output | 8 | Interrupt enable register value |
| isr_o | output | 8 | Interrupt status register value |
| fcr_o | output | 8 | FIFO control register value |
| mcr_o | output | 8 | Modem control register value |
| feat_o | output | 8 | Feature register value |
| scratch_o | output | 8 | Scratchpad value |

## Verification
A write is due at the field outputs one clock edge after its strobe is sampled. rdata_o follows the address with no delay and reflects a write from the edge that stores it. The bench drives inputs on the falling edge. A behavioural model applies each write at the rising edge, with the write mask taken from the model's unlock bit as it stood before that edge. The bench compares every output on the following falling edge, so each result is checked half a cycle after it is due. Fixed-value checks at the lock and unlock transitions pin down the single-cycle delay of the unlock bit.

// File: rtl/enh_regbank_pkg.sv
package enh_regbank_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NREG = 6;
  localparam int UNLOCK_BIT = 4;

  typedef enum logic [AW-1:0] {
    A_IER  = 3'd0,
    A_ISR  = 3'd1,
    A_FCR  = 3'd2,
    A_MCR  = 3'd3,
    A_FEAT = 3'd4,
    A_SCR  = 3'd5
  } reg_addr_e;

  function automatic logic [DW-1:0] prot_mask(input int idx);
    case (idx)
      0:       return 8'hF0;
      1:       return 8'h30;
      2:       return 8'h30;
      3:       return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/enh_regbank_cell.sv
module enh_regbank_cell #(
  parameter int            W    = 8,
  parameter logic [W-1:0]  PROT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         unlock_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] wmask;
  assign wmask = unlock_i ? {W{1'b1}} : ~PROT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= (q_o & ~wmask) | (wdata_i & wmask);
  end

  assert_locked_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_i |=> ((q_o & PROT) == ($past(q_o) & PROT)));
  assert_open_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & ~PROT) == ($past(wdata_i) & ~PROT)));
  assert_unlocked_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && unlock_i) |=> (q_o == $past(wdata_i)));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/enh_regbank_rdmux.sv
module enh_regbank_rdmux #(
  parameter int N  = 6,
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic [W-1:0]  regs_i [N],
  input  logic [AW-1:0] addr_i,
  output logic [W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (addr_i == AW'(i)) rdata_o = regs_i[i];
  end
endmodule

// File: rtl/enh_regbank.sv
module enh_regbank
  import enh_regbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ier_o,
  output logic [DW-1:0] isr_o,
  output logic [DW-1:0] fcr_o,
  output logic [DW-1:0] mcr_o,
  output logic [DW-1:0] feat_o,
  output logic [DW-1:0] scratch_o
);
  logic [DW-1:0] regs [NREG];
  logic          unlock;

  // unlock comes from the stored feature bit, so a change applies next cycle
  assign unlock = regs[A_FEAT][UNLOCK_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic sel_we;
    assign sel_we = we_i && (addr_i == AW'(g));
    enh_regbank_cell #(.W(DW), .PROT(prot_mask(g))) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (sel_we),
      .unlock_i (unlock),
      .wdata_i  (wdata_i),
      .q_o      (regs[g])
    );
  end

  enh_regbank_rdmux #(.N(NREG), .W(DW), .AW(AW)) u_rdmux (
    .regs_i  (regs),
    .addr_i  (addr_i),
    .rdata_o (rdata_o)
  );

  assign ier_o     = regs[A_IER];
  assign isr_o     = regs[A_ISR];
  assign fcr_o     = regs[A_FCR];
  assign mcr_o     = regs[A_MCR];
  assign feat_o    = regs[A_FEAT];
  assign scratch_o = regs[A_SCR];

  assert_unlock_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FEAT) |=> (feat_o[UNLOCK_BIT] == $past(wdata_i[UNLOCK_BIT])));
  assert_scratch_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SCR) |=> (scratch_o == $past(wdata_i)));
  assert_unmapped_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > 3'd5) |-> (rdata_o == 8'h00));
endmodule

// File: tb/tb_enh_regbank.sv
`timescale 1ns/1ps
module tb_enh_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata, ier, isr, fcr, mcr, feat, scr;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  logic [7:0] m [6];

  always #2.5 clk = ~clk;

  enh_regbank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .ier_o(ier), .isr_o(isr), .fcr_o(fcr), .mcr_o(mcr),
    .feat_o(feat), .scratch_o(scr)
  );

  function automatic logic [7:0] pmask(input int a);
    case (a)
      0: return 8'hF0;
      1: return 8'h30;
      2: return 8'h30;
      3: return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction

  // behavioural reference: write mask uses unlock as it was before the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m[i] = 8'h00;
    end else if (we && addr < 3'd6) begin
      if (m[4][4]) m[addr] = wdata;
      else m[addr] = (m[addr] & pmask(addr)) | (wdata & ~pmask(addr));
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({tag, " R9 ier"}, ier, m[0]);
      chk({tag, " R9 isr"}, isr, m[1]);
      chk({tag, " R9 fcr"}, fcr, m[2]);
      chk({tag, " R9 mcr"}, mcr, m[3]);
      chk({tag, " R9 feat"}, feat, m[4]);
      chk({tag, " R9 scr"}, scr, m[5]);
      chk({tag, " R7 rdata"}, rdata, (addr < 3'd6) ? m[addr] : 8'h00);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic e = 1'b1);
    @(negedge clk);
    #0.5 addr = a; wdata = d; we = e;
  endtask

  task automatic idle(input logic [2:0] a);
    @(negedge clk);
    #0.5 addr = a; we = 1'b0;
  endtask

  initial begin
    #1000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    #1;
    tag = "R1";
    chk("R1 ier reset", ier, 8'h00);
    chk("R1 feat reset", feat, 8'h00);
    chk("R1 scr reset", scr, 8'h00);
    // R2 scratchpad under lock
    tag = "R2";
    wr(3'd5, 8'hA5); wr(3'd5, 8'h5A); idle(3'd5);
    #2 chk("R2 scratch readback", rdata, 8'h5A);
    // R5 locked writes
    tag = "R5";
    for (int a = 0; a < 4; a++) wr(3'(a), 8'hFF);
    idle(3'd0);
    #2 chk("R5 ier locked", ier, 8'h0F);
    chk("R5 mcr locked", mcr, 8'h1F);
    chk("R5 isr locked", isr, 8'hCF);
    // R6 unlock then immediate write
    tag = "R6";
    wr(3'd4, 8'h10); wr(3'd0, 8'hFF); idle(3'd0);
    #2 chk("R6 ier after unlock", ier, 8'hFF);
    // R4 unlocked writes
    tag = "R4";
    wr(3'd1, 8'hA5); wr(3'd2, 8'h3C); wr(3'd3, 8'hC3); idle(3'd2);
    #2 chk("R4 fcr unlocked", fcr, 8'h3C);
    // R3 feature other bits, unlock kept
    tag = "R3";
    wr(3'd4, 8'hFF); wr(3'd4, 8'h1A); idle(3'd4);
    #2 chk("R3 feat readback", rdata, 8'h1A);
    // R6 lock latches then writes blocked
    tag = "R6";
    wr(3'd4, 8'h00); wr(3'd0, 8'h00); wr(3'd3, 8'h00); idle(3'd0);
    #2 chk("R6 ier latched", ier, 8'hF0);
    chk("R6 mcr latched", mcr, 8'hC0);
    // R8 strobe low
    tag = "R8";
    wr(3'd5, 8'h77, 1'b0); wr(3'd4, 8'h10, 1'b0); wr(3'd1, 8'h00, 1'b0); idle(3'd5);
    #2 chk("R8 no-strobe scratch", rdata, 8'h5A);
    // R7 unmapped addresses
    tag = "R7";
    wr(3'd6, 8'hEE); wr(3'd7, 8'hDD); idle(3'd7);
    #2 chk("R7 unmapped read", rdata, 8'h00);
    idle(3'd6);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule